// File: doc/BRIEF.md
# Truncated timestamp seconds reconstructor

A frame timestamp is often captured with the full nanosecond count but only a few low bits of the seconds count, to fit the timestamp into two narrow words. This block rebuilds the full seconds value by combining the captured low seconds bits with the upper bits of the live timer's seconds count. The timer is read some time after the capture. If its low seconds bits have wrapped past zero in between, the block moves the upper part back by one field range.

The captured seconds field is SEC_W bits wide. Its low part sits in the top bits of the first word, directly above the nanoseconds. Its high part sits in the bottom bits of the second word. A sample is accepted when `in_valid` is high. The rebuilt timestamp appears one clock later with `out_valid`. The correction is only right when the capture is less than half a field range (2^(SEC_W-1) seconds) older than the timer reading.

Top module: `ts_sec_rebuild`

## Requirements
- R1: While and just after reset, `out_valid` is 0 and `out_sec` and `out_ns` are 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. Back-to-back samples each produce one result.
- R3: `out_ns` equals bits [NS_W-1:0] (default [29:0]) of `cap_lo` for the accepted sample.
- R4: The captured seconds field is {`cap_hi`[HI_SEC_W-1:0], `cap_lo`[31:NS_W]}. With the defaults this is `cap_hi`[3:0] above `cap_lo`[31:30], 6 bits. `out_sec`[SEC_W-1:0] always equals this field.
- R5: No wrap applies when the field's top bit (bit 5) is 0, or when `timer_sec` bit 5 is 1. Then `out_sec` = (`timer_sec` with bits [5:0] cleared) + field.
- R6: A wrap applies when the field's top bit is 1 and `timer_sec` bit 5 is 0. Then `out_sec` = ((`timer_sec` with bits [5:0] cleared) + field − 2^SEC_W), modulo 2^48. A zero timer therefore gives an all-ones result when the field is 63.
- R7: When `in_valid` is low, `out_sec` and `out_ns` keep their values.
- R8: The bits of `cap_hi` above the seconds field have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A captured sample is presented this cycle |
| cap_lo | input | 32 | First captured word: low seconds bits on top, nanoseconds below |
| cap_hi | input | 32 | Second captured word: high seconds bits at the bottom |
| timer_sec | input | 48 | Current full seconds count of the live timer |
| out_valid | output | 1 | Rebuilt timestamp is valid |
| out_sec | output | 48 | Rebuilt full seconds |
| out_ns | output | 30 | Nanoseconds of the rebuilt timestamp |

## Verification
The assertions check on every cycle that `out_valid` follows `in_valid` by exactly one cycle. They also check that the outputs hold when no sample is given, that the low seconds bits and the nanoseconds pass through unchanged, and that the seconds value matches the wrap or no-wrap arithmetic for the inputs of the previous cycle. Some cases can only be shown by the bench's scenarios. These are the exact boundaries where the wrap decision flips (the field at half range and at full range against timer low bits on either side of the half point), the underflow of a zero timer, and whether the unused upper bits of the second word are really ignored.

// File: rtl/ts_sec_rebuild.sv
module ts_sec_rebuild #(
  parameter int SEC_W   = 6,
  parameter int NS_W    = 30,
  parameter int WORD_W  = 32,
  parameter int TIMER_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  cap_lo,
  input  logic [WORD_W-1:0]  cap_hi,
  input  logic [TIMER_W-1:0] timer_sec,
  output logic               out_valid,
  output logic [TIMER_W-1:0] out_sec,
  output logic [NS_W-1:0]    out_ns
);
  localparam int LO_SEC_W = WORD_W - NS_W;
  localparam int HI_SEC_W = SEC_W - LO_SEC_W;
  localparam int UP_W     = TIMER_W - SEC_W;

  logic [SEC_W-1:0] cap_field;
  logic             wrapped;
  logic [UP_W-1:0]  upper;
  logic             unused_bits;

  assign cap_field   = {cap_hi[HI_SEC_W-1:0], cap_lo[WORD_W-1:NS_W]};
  assign wrapped     = cap_field[SEC_W-1] & ~timer_sec[SEC_W-1];
  assign upper       = timer_sec[TIMER_W-1:SEC_W] - UP_W'(wrapped);
  assign unused_bits = ^{cap_hi[WORD_W-1:HI_SEC_W], timer_sec[SEC_W-2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sec   <= '0;
      out_ns    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sec <= {upper, cap_field};
        out_ns  <= cap_lo[NS_W-1:0];
      end
    end
  end

  localparam logic [TIMER_W-1:0] LOW_MASK = TIMER_W'((64'd1 << SEC_W) - 64'd1);
  localparam logic [TIMER_W-1:0] RANGE    = TIMER_W'(64'd1 << SEC_W);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_sec) && $stable(out_ns)));

  assert_ns_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ns == $past(cap_lo[NS_W-1:0]));

  assert_low_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sec[SEC_W-1:0] ==
      {$past(cap_hi[HI_SEC_W-1:0]), $past(cap_lo[WORD_W-1:NS_W])});

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !($past(cap_lo[WORD_W-1]) == 1'b1 && HI_SEC_W == 0) &&
     !($past(cap_hi[HI_SEC_W-1]) && !$past(timer_sec[SEC_W-1]))) |->
      out_sec == (($past(timer_sec) & ~LOW_MASK) +
                  TIMER_W'({$past(cap_hi[HI_SEC_W-1:0]), $past(cap_lo[WORD_W-1:NS_W])})));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cap_hi[HI_SEC_W-1]) && !$past(timer_sec[SEC_W-1])) |->
      out_sec == (($past(timer_sec) & ~LOW_MASK) +
                  TIMER_W'({$past(cap_hi[HI_SEC_W-1:0]), $past(cap_lo[WORD_W-1:NS_W])}) - RANGE));
endmodule

// File: tb/ts_sec_rebuild_test.sv
module ts_sec_rebuild_test;
  localparam int SEC_W = 6;
  localparam int NS_W  = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] cap_lo = '0;
  logic [31:0] cap_hi = '0;
  logic [47:0] timer_sec = '0;
  logic        out_valid;
  logic [47:0] out_sec;
  logic [29:0] out_ns;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ts_sec_rebuild uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .timer_sec(timer_sec), .out_valid(out_valid),
    .out_sec(out_sec), .out_ns(out_ns)
  );

  function automatic logic [47:0] want_sec(logic [31:0] lo, logic [31:0] hi, logic [47:0] tm);
    logic [47:0] field;
    logic [47:0] base;
    field = 48'({hi[3:0], lo[31:30]});
    base  = tm & ~48'h3F;
    if (field[5] && !tm[5]) return base + field - 48'd64;
    return base + field;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] lo, logic [31:0] hi, logic [47:0] tm, string req);
    logic [47:0] es;
    es = want_sec(lo, hi, tm);
    @(negedge clk);
    in_valid = 1'b1; cap_lo = lo; cap_hi = hi; timer_sec = tm;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " sec"}, 64'(out_sec), 64'(es));
    check({req, " ns"}, 64'(out_ns), 64'(lo[29:0]));
  endtask

  function automatic logic [31:0] mk_lo(logic [5:0] f, logic [29:0] ns);
    return {f[1:0], ns};
  endfunction

  function automatic logic [31:0] mk_hi(logic [5:0] f);
    return {28'd0, f[5:2]};
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [47:0] s0;
    logic [29:0] n0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(out_valid), 64'd0);
    check("R1 sec in reset", 64'(out_sec), 64'd0);
    check("R1 ns in reset", 64'(out_ns), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 64'(out_valid), 64'd0);
    check("R1 sec after reset", 64'(out_sec), 64'd0);

    send(mk_lo(6'd5, 30'd123456789), mk_hi(6'd5), 48'h0000_1234_5607, "R5 plain");
    send(mk_lo(6'd31, 30'd999999999), mk_hi(6'd31), 48'h0000_0000_10E0, "R5 field 31 timer 32");
    send(mk_lo(6'd32, 30'd1), mk_hi(6'd32), 48'h0000_0000_1000, "R6 field 32 timer low 0");
    send(mk_lo(6'd32, 30'd2), mk_hi(6'd32), 48'h0000_0000_1020, "R5 field 32 timer low 32");
    send(mk_lo(6'd63, 30'd3), mk_hi(6'd63), 48'h0000_0000_101F, "R6 field 63 timer low 31");
    send(mk_lo(6'd63, 30'd4), mk_hi(6'd63), 48'h0000_0000_1020, "R5 field 63 timer low 32");
    send(mk_lo(6'd63, 30'd5), mk_hi(6'd63), 48'h0000_0000_1000, "R6 field 63 timer low 0");
    send(mk_lo(6'd63, 30'd6), mk_hi(6'd63), 48'h0, "R6 zero timer underflow");
    check("R6 underflow all ones", 64'(out_sec), 64'hFFFF_FFFF_FFFF);
    send(mk_lo(6'd0, 30'd7), mk_hi(6'd0), 48'hFFFF_FFFF_FFFF, "R5 field 0 timer max");
    send(mk_lo(6'd42, 30'd0), mk_hi(6'd42), 48'h0000_0000_0040, "R4 field layout");
    check("R4 low bits", 64'(out_sec[5:0]), 64'd42);

    s0 = out_sec; n0 = out_ns;
    @(negedge clk);
    cap_lo = 32'hFFFF_FFFF; cap_hi = 32'hFFFF_FFFF; timer_sec = 48'h1234;
    @(negedge clk);
    check("R7 sec held", 64'(out_sec), 64'(s0));
    check("R7 ns held", 64'(out_ns), 64'(n0));
    check("R2 no valid when idle", 64'(out_valid), 64'd0);

    send(mk_lo(6'd45, 30'd77), 32'hABCD_E000 | mk_hi(6'd45), 48'h0000_0000_2000, "R8 junk upper bits");
    s0 = out_sec;
    send(mk_lo(6'd45, 30'd77), mk_hi(6'd45), 48'h0000_0000_2000, "R8 clean upper bits");
    check("R8 same result", 64'(out_sec), 64'(s0));

    begin
      logic [31:0] la, ha, lb, hb;
      logic [47:0] ta, tb;
      la = $urandom; ha = $urandom; ta = {16'($urandom), 32'($urandom)};
      lb = $urandom; hb = $urandom; tb = {16'($urandom), 32'($urandom)};
      @(negedge clk);
      in_valid = 1'b1; cap_lo = la; cap_hi = ha; timer_sec = ta;
      @(negedge clk);
      cap_lo = lb; cap_hi = hb; timer_sec = tb;
      check("R2 first of pair", 64'(out_valid), 64'd1);
      check("R6 first of pair sec", 64'(out_sec), 64'(want_sec(la, ha, ta)));
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 second of pair", 64'(out_valid), 64'd1);
      check("R5 second of pair sec", 64'(out_sec), 64'(want_sec(lb, hb, tb)));
      check("R3 second of pair ns", 64'(out_ns), 64'(lb[29:0]));
      @(negedge clk);
      check("R2 valid drops", 64'(out_valid), 64'd0);
    end

    for (int i = 0; i < 300; i++) begin
      logic [47:0] tm;
      logic [5:0] age;
      logic [5:0] f;
      tm = {16'($urandom), 32'($urandom)};
      age = 6'($urandom_range(0, 31));
      f = tm[5:0] - age;
      send(mk_lo(f, 30'($urandom)), ($urandom & 32'hFFFF_FFF0) | mk_hi(f), tm, "R6 random");
      if (out_sec > tm || (tm - out_sec) > 48'd31)
        check("R6 random age window", 64'(tm - out_sec), 64'(age));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule